// File: doc/BRIEF.md
# Chainable 24-bit Serial Register Slave

This block is the serial front end of a register-mapped peripheral. A host talks to it over a four-wire serial link made up of chip select, serial clock, data in and data out. Several identical slaves can share one chip select and one serial clock by wiring each slave's data out to the next slave's data in. Each slave holds a 24-bit shifter. Data is captured on the falling serial-clock edge and driven out on the rising edge. Once a frame has run past 24 clocks, the oldest bits leave through data out toward the next slave, so a chain of N slaves takes exactly 24·N clocks per frame.

The frame is acted on only when chip select rises, and only if the number of clocks in the frame is a non-zero multiple of 24. Bit 23 selects the action: 1 is a read and 0 is a write. Bits 22:16 carry a 7-bit address. Bits 15:0 carry the write data, which a read ignores. Eight 16-bit registers sit at addresses 0 to 7. A read returns its answer in the next frame: at the next chip-select fall the shifter is preloaded with {1, address, data}, and this word then leaves MSB first. The serial pins are synchronised to a system clock that runs at least four times faster than the serial clock.

Control is a three-state machine. ST_IDLE waits with chip select high. On a chip-select fall it preloads the shifter and moves to ST_SHIFT. ST_SHIFT moves serial bits and counts falling edges modulo 24. On a chip-select rise it goes to ST_COMMIT if the count is aligned, and otherwise goes back to ST_IDLE and discards the frame. ST_COMMIT performs the write or captures the read answer in one system cycle, then returns to ST_IDLE.

Top module: `spi_chain_slave`

## Requirements
- R1: Serial-clock edges while chip select is high do not shift the shifter, change data out or touch any register.
- R2: Data in is captured on each falling serial-clock edge into a 24-bit shifter. The bit captured on falling edge i appears on data out after rising edge i+24, which passes the stream through to the next slave.
- R3: Data out changes only after a rising serial-clock edge inside a frame, or at the chip-select fall that starts a frame.
- R4: A rising chip select commits the shifter only when the frame held a non-zero multiple of 24 falling edges. Any other frame is discarded, with no write and no new read answer.
- R5: A committed frame with bit 23 = 0 writes bits 15:0 to the register addressed by bits 22:16. Addresses 0 to 7 hold 16-bit registers, and writes to any other address have no effect.
- R6: A committed frame with bit 23 = 1 makes the next frame shift out {1, address[6:0], data[15:0]} MSB first. Unmapped addresses return zero data.
- R7: A read answer is offered only in the frame directly after its read. Every chip-select fall consumes the pending answer, and a slave with no pending answer shifts out bits that carry no meaning.
- R8: After reset, data out is 0, all registers read as zero and no answer is pending.
- R9: Frames work with a gated burst clock and with a free-running serial clock. Only the edges inside the chip-select-low window count.
- R10: If a chip-select fall and the first rising serial-clock edge reach the block in the same system cycle, the first bit out is still the MSB of the pending answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in, captured on falling edges |
| sdo | output | 1 | Serial data out, updated on rising edges |

## Verification
Two events can land in the same system cycle: the preload of a pending answer at the chip-select fall, and the first rising serial-clock edge. This can happen because both pins pass through synchronisers of equal depth. The bench provokes it by dropping chip select and raising the serial clock at the same instant for two frames of a three-slave chain. It judges the result by comparing the full 72-bit stream received at the far end against a reference model, checking the leading bit of each slave's answer in particular. A discarded 71-clock frame placed just before one of these frames also shows that pending answers are consumed and that no write was taken.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

    localparam int DEF_ADDR_W   = 7;
    localparam int DEF_DATA_W   = 16;
    localparam int DEF_NUM_REGS = 8;
    localparam int DEF_SYNC_W   = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } fsm_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int SYNC_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic sdi_s
);

    logic [SYNC_W-1:0] sclk_q;
    logic [SYNC_W-1:0] cs_q;
    logic [SYNC_W-1:0] sdi_q;
    logic              sclk_d;
    logic              cs_d;

    // sdi goes through the same depth as sclk, so at a detected falling
    // edge sdi_s holds the value present when the pin fell.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            sdi_q  <= '0;
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_q <= {sclk_q[SYNC_W-2:0], sclk};
            cs_q   <= {cs_q[SYNC_W-2:0], cs_n};
            sdi_q  <= {sdi_q[SYNC_W-2:0], sdi};
            sclk_d <= sclk_q[SYNC_W-1];
            cs_d   <= cs_q[SYNC_W-1];
        end
    end

    assign sclk_rise = sclk_q[SYNC_W-1] & ~sclk_d;
    assign sclk_fall = ~sclk_q[SYNC_W-1] & sclk_d;
    assign cs_fall   = ~cs_q[SYNC_W-1] & cs_d;
    assign cs_rise   = cs_q[SYNC_W-1] & ~cs_d;
    assign sdi_s     = sdi_q[SYNC_W-1];

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] regs [NUM_REGS];

    // One storage word per mapped address; other addresses match no word.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (addr == ADDR_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == ADDR_W'(i)) begin
                rd_data = regs[i];
            end
        end
    end

endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_chain_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int DATA_W  = 16,
    parameter int FRAME_W = 1 + ADDR_W + DATA_W,
    parameter int CNT_W   = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    input  logic               cs_fall,
    input  logic               cs_rise,
    input  logic               sdi_s,
    input  logic [DATA_W-1:0]  rd_data,
    output logic [ADDR_W-1:0]  reg_addr,
    output logic [DATA_W-1:0]  wr_data,
    output logic               wr_en,
    output logic               sdo,
    output fsm_t               state_o,
    output logic [CNT_W-1:0]   bitcnt_o,
    output logic               frame_full_o,
    output logic               pending_o,
    output logic [FRAME_W-1:0] shreg_o
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
    localparam int               MSB      = FRAME_W - 1;

    fsm_t               state, state_nx;
    logic [FRAME_W-1:0] shreg;
    logic [FRAME_W-1:0] rsp;
    logic [CNT_W-1:0]   bitcnt;
    logic               frame_full;
    logic               pending;
    logic               aligned;
    logic               is_read;
    logic [FRAME_W-1:0] preload;

    assign aligned = frame_full && (bitcnt == '0);
    assign is_read = shreg[MSB];
    assign preload = pending ? rsp : '0;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cs_fall) state_nx = ST_SHIFT;
            ST_SHIFT:  if (cs_rise) state_nx = aligned ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Datapath registers driven by the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            rsp        <= '0;
            bitcnt     <= '0;
            frame_full <= 1'b0;
            pending    <= 1'b0;
            sdo        <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cs_fall) begin
                        // Frame start: hand over the answer and drive its MSB at once,
                        // which also covers a rising edge landing in this cycle.
                        shreg      <= preload;
                        sdo        <= preload[MSB];
                        pending    <= 1'b0;
                        bitcnt     <= '0;
                        frame_full <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (sclk_rise) begin
                        sdo <= shreg[MSB];
                    end
                    if (sclk_fall) begin
                        shreg <= {shreg[MSB-1:0], sdi_s};
                        if (bitcnt == CNT_LAST) begin
                            bitcnt     <= '0;
                            frame_full <= 1'b1;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_COMMIT: begin
                    if (is_read) begin
                        rsp     <= {1'b1, reg_addr, rd_data};
                        pending <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        reg_addr     = shreg[MSB-1 -: ADDR_W];
        wr_data      = shreg[DATA_W-1:0];
        wr_en        = (state == ST_COMMIT) && !is_read;
        state_o      = state;
        bitcnt_o     = bitcnt;
        frame_full_o = frame_full;
        pending_o    = pending;
        shreg_o      = shreg;
    end

endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
    import spi_chain_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int NUM_REGS = DEF_NUM_REGS,
    parameter int SYNC_W   = DEF_SYNC_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sdo
);

    localparam int FRAME_W = 1 + ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W);

    logic               sclk_rise, sclk_fall, cs_fall, cs_rise, sdi_s;
    logic [ADDR_W-1:0]  reg_addr;
    logic [DATA_W-1:0]  wr_data, rd_data;
    logic               wr_en;
    fsm_t               state;
    logic [CNT_W-1:0]   bitcnt;
    logic               frame_full;
    logic               pending;
    logic [FRAME_W-1:0] shreg;

    spi_pin_sync #(.SYNC_W(SYNC_W)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sdi_s     (sdi_s)
    );

    spi_frame_fsm #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_rise    (sclk_rise),
        .sclk_fall    (sclk_fall),
        .cs_fall      (cs_fall),
        .cs_rise      (cs_rise),
        .sdi_s        (sdi_s),
        .rd_data      (rd_data),
        .reg_addr     (reg_addr),
        .wr_data      (wr_data),
        .wr_en        (wr_en),
        .sdo          (sdo),
        .state_o      (state),
        .bitcnt_o     (bitcnt),
        .frame_full_o (frame_full),
        .pending_o    (pending),
        .shreg_o      (shreg)
    );

    spi_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (reg_addr),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/spi_chain_slave_chk.sv
module spi_chain_slave_chk
    import spi_chain_pkg::*;
#(
    parameter int FRAME_W = 24,
    parameter int CNT_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sclk_rise,
    input logic               cs_fall,
    input fsm_t               state,
    input logic [CNT_W-1:0]   bitcnt,
    input logic               frame_full,
    input logic               pending,
    input logic               wr_en,
    input logic [FRAME_W-1:0] shreg,
    input logic               sdo
);

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !cs_fall) |=> $stable(shreg)); // R1

    AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt < CNT_W'(FRAME_W)); // R2

    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_rise || cs_fall) |=> $stable(sdo)); // R3

    AST_WRITE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(state) == ST_SHIFT && bitcnt == '0 && frame_full)); // R4

    AST_PEND_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cs_fall) |=> !pending); // R7

endmodule

bind spi_chain_slave spi_chain_slave_chk #(
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_rise  (sclk_rise),
    .cs_fall    (cs_fall),
    .state      (state),
    .bitcnt     (bitcnt),
    .frame_full (frame_full),
    .pending    (pending),
    .wr_en      (wr_en),
    .shreg      (shreg),
    .sdo        (sdo)
);

// File: tb/spi_chain_slave_bench.sv
module spi_chain_slave_bench;

    localparam int HALF = 32;   // serial half period in ns (8 system clocks)
    localparam int QTR  = HALF / 2;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    logic sdo_a, sdo_b, sdo_c;
    int   n_checks = 0, n_fail = 0;
    bit   finished = 0;

    // reference model: device 0 = A (nearest the host), 2 = C
    logic [15:0] mreg  [3][8];
    bit          mpend [3];
    logic [23:0] mrsp  [3];

    logic [71:0] exp_q [$];
    logic [2:0]  msk_q [$];
    string       tag_q [$];
    logic [71:0] got_q [$];

    always #2 clk = ~clk;

    spi_chain_slave u_spi_chain_slave (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),   .sdo(sdo_a));
    spi_chain_slave u_spi_chain_slave_b (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdo_a), .sdo(sdo_b));
    spi_chain_slave u_spi_chain_slave_c (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdo_b), .sdo(sdo_c));

    function automatic logic [23:0] wr(input logic [6:0] a, input logic [15:0] d);
        return {1'b0, a, d};
    endfunction

    function automatic logic [23:0] rd(input logic [6:0] a);
        return {1'b1, a, 16'h0000};
    endfunction

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_clocks(input int n);
        for (int k = 0; k < n; k++) begin
            sdi = ~sdi; sclk = 1'b1; #(HALF);
            sclk = 1'b0; #(HALF);
        end
    endtask

    // One chained frame: C's command goes first, A's last.
    task automatic frame(input logic [23:0] ca, input logic [23:0] cb, input logic [23:0] cc,
                         input int nbits, input bit cont, input bit fast, input string req);
        logic [71:0] tx, got, got_a;
        logic [2:0]  msk;
        logic        pa, pc;
        tx = {cc, cb, ca};
        got = '0; got_a = '0;
        msk = (nbits == 72) ? {mpend[2], mpend[1], mpend[0]} : 3'b000;
        exp_q.push_back({mrsp[2], mrsp[1], mrsp[0]});
        msk_q.push_back(msk);
        tag_q.push_back(req);
        for (int d = 0; d < 3; d++) mpend[d] = 0;   // R7: consumed at every frame start
        if (cont) begin
            pa = sdo_a; pc = sdo_c;
            idle_clocks(4);
            check("R1 clocks with cs high", {70'd0, sdo_c, sdo_a}, {70'd0, pc, pa});
        end
        cs_n = 1'b0;
        sdi  = tx[71];
        if (!fast) #(HALF);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b1; #(HALF);
            if (i < 72) begin got[71-i] = sdo_c; got_a[71-i] = sdo_a; end
            sclk = 1'b0; #(QTR);
            if (i + 1 < 72) sdi = tx[71-(i+1)];
            #(QTR);
        end
        cs_n = 1'b1;
        if (nbits == 72) begin
            got_q.push_back(got);
            check("R2 pass-through at A", {24'd0, got_a[47:0]}, {24'd0, tx[71:24]});
        end else begin
            got_q.push_back('0);
        end
        if (cont) idle_clocks(4);
        #(2*HALF);
        if (nbits > 0 && nbits % 24 == 0) begin
            for (int d = 0; d < 3; d++) begin
                logic [23:0] c;
                c = tx[24*d +: 24];
                if (c[23]) begin
                    mpend[d] = 1;
                    mrsp[d]  = {1'b1, c[22:16], (c[22:16] < 7'd8) ? mreg[d][c[18:16]] : 16'h0000};
                end else if (c[22:16] < 7'd8) begin
                    mreg[d][c[18:16]] = c[15:0];
                end
            end
        end
    endtask

    // Monitor: compare each finished frame against its expected answers
    initial begin
        forever begin
            @(negedge clk);
            if (got_q.size() > 0) begin
                logic [71:0] g, e;
                logic [2:0]  m;
                string       t;
                g = got_q.pop_front(); e = exp_q.pop_front();
                m = msk_q.pop_front(); t = tag_q.pop_front();
                for (int d = 0; d < 3; d++) begin
                    if (m[d]) check(t, {48'd0, g[24*d +: 24]}, {48'd0, e[24*d +: 24]});
                end
            end
        end
    end

    initial begin
        #(400_000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int d = 0; d < 3; d++) begin
            mpend[d] = 0; mrsp[d] = '0;
            for (int r = 0; r < 8; r++) mreg[d][r] = '0;
        end
        #(40);
        rst_n = 1'b1;
        #(20);
        check("R8 sdo after reset", {69'd0, sdo_c, sdo_b, sdo_a}, 72'd0);

        // R8: fresh registers read zero; R6 answer format
        frame(rd(7'd0), rd(7'd7), rd(7'd3), 72, 0, 0, "R8 reset contents");
        frame(wr(7'd1, 16'h1234), wr(7'd2, 16'hBEEF), wr(7'd7, 16'hA5A5), 72, 0, 0, "R6 read of reset regs");
        // R9: free-running clock frames
        frame(rd(7'd1), rd(7'd2), rd(7'd7), 72, 1, 0, "R9 continuous");
        frame(rd(7'h55), wr(7'd2, 16'h0001), rd(7'd7), 72, 1, 0, "R5 readback after write");
        // R5: write to unmapped address has no effect; R6 unmapped reads zero
        frame(wr(7'h55, 16'hFFFF), wr(7'd5, 16'h5A5A), wr(7'd0, 16'h7777), 72, 0, 0, "R6 unmapped read");
        // R4: 71-clock frame is discarded
        frame(wr(7'd1, 16'hDEAD), wr(7'd5, 16'hDEAD), rd(7'd0), 71, 0, 0, "R4 short frame");
        // R10: chip-select fall together with the first rising edge
        frame(rd(7'h55), rd(7'd5), rd(7'd0), 72, 0, 1, "R7 no answer after discard");
        frame(rd(7'd1), rd(7'd2), rd(7'd3), 72, 0, 1, "R10 coincident start");
        frame(wr(7'd6, 16'h0F0F), rd(7'h7F), wr(7'd1, 16'h1111), 72, 1, 0, "R4 discarded writes absent");
        frame(rd(7'd6), wr(7'd3, 16'h3333), rd(7'd1), 72, 0, 0, "R6 top unmapped address");
        frame(wr(7'd0, 16'h0000), rd(7'd3), wr(7'd2, 16'h2222), 72, 1, 0, "R5 second writes");
        frame(wr(7'd0, 16'h0000), wr(7'd0, 16'h0000), wr(7'd0, 16'h0000), 72, 0, 0, "R6 last answers");

        while (got_q.size() > 0) @(negedge clk);
        #(20);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule